// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder with Link, Indexed Load and Memory Jump

This block is the main control decoder for a 32-bit single-cycle load/store processor. It is purely combinational. From the 6-bit opcode and the 6-bit function field of the current instruction word, it produces every datapath steering signal in the same cycle. The ALU control decoder, register file and memories sit outside it and only consume its outputs.

The decoder covers the base set: register-format ALU operations, word load, word store, branch-on-equal and the direct jump. It also covers three additions.

- **Call.** A call with link writes the address of the next instruction into register 31 and jumps.
- **Indexed load.** An indexed load uses the register format and computes its address as the sum of two source registers.
- **Memory jump.** An indirect jump reads its target word from memory at base plus signed offset.

To serve the additions, the write-destination, write-source and next-PC selects are each two bits wide.

Top module: `sc_main_ctl`

## Requirements
- R1: Opcode 0 with any function value other than 0x3A gives write-dest = 01 (rd), ALU B from register (0), write-source = 00 (ALU), register write = 1, ALU mode = 10 (from function field), and no memory access, branch or jump.
- R2: Opcode 35 (word load) gives write-dest = 00 (rt), ALU B = immediate (1), write-source = 01 (memory), register write = 1, memory read = 1, ALU mode = 00 (add) and next-PC = 00. The function field has no effect.
- R3: Opcode 43 (word store) gives ALU B = immediate (1), memory write = 1 and ALU mode = 00, with register write and memory read at 0.
- R4: Opcode 4 (branch-on-equal) gives branch = 1 and ALU mode = 01 (subtract), with ALU B from register and no write or memory access.
- R5: Opcode 2 (direct jump) gives next-PC select = 01 (jump target), with every enable at 0.
- R6: Opcode 3 (call with link) gives write-dest = 10 (constant register 31), write-source = 10 (PC+4), register write = 1, next-PC = 01, and no memory access or branch.
- R7: Opcode 0 with function 0x3A (indexed load) takes priority over the R1 row and gives write-dest = 01, ALU B from register, write-source = 01, register write = 1, memory read = 1, memory write = 0 and ALU mode = 00.
- R8: Opcode 0x3C (memory jump) gives ALU B = immediate (1), ALU mode = 00, memory read = 1, next-PC = 10 (memory data), and register write, memory write and branch at 0.
- R9: Any other opcode drives every output to zero. This includes all enables and next-PC = 00.
- R10: Every output that a row above leaves open is driven to zero, so each instruction yields exactly one 13-bit control vector.
- R11: No instruction asserts memory read and memory write together, and no select ever takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Major opcode field of the instruction |
| funct_i | input | 6 | Function field of the instruction |
| wb_dst_sel_o | output | 2 | Register write destination: 00 rt, 01 rd, 10 register 31 |
| alu_b_imm_o | output | 1 | ALU second operand: 0 register, 1 sign-extended immediate |
| wb_src_sel_o | output | 2 | Register write data: 00 ALU, 01 memory, 10 PC+4 |
| rf_we_o | output | 1 | Register file write enable |
| dm_re_o | output | 1 | Data memory read enable |
| dm_we_o | output | 1 | Data memory write enable |
| br_en_o | output | 1 | Conditional branch qualifier |
| alu_mode_o | output | 2 | ALU mode: 00 add, 01 subtract, 10 from function field |
| pc_src_sel_o | output | 2 | Next PC: 00 sequential/branch, 01 jump target, 10 memory data |

## Verification
The embedded checks assume that the opcode and function inputs hold known 0/1 values whenever they are evaluated. Each check is skipped while either input carries an unknown bit, so only real instruction words are judged. The bench drives every one of the 64 opcodes, and it steps the function field through both the indexed-load code and values around it. It always applies an input one clock edge before sampling at the next falling edge, so the outputs are fully settled when read.

// File: rtl/sc_ctl_pkg.sv
// Package: shared encodings and the control bundle for the main decoder.
// Assumes a 6-bit opcode and a 6-bit function field.
package sc_ctl_pkg;

    localparam int OP_W = 6;
    localparam int FN_W = 6;

    // Instruction classes, one bit each in the class vector.
    localparam int CL_RTYPE = 0;
    localparam int CL_IDXLD = 1;
    localparam int CL_LOAD  = 2;
    localparam int CL_STORE = 3;
    localparam int CL_BEQ   = 4;
    localparam int CL_JMP   = 5;
    localparam int CL_CALL  = 6;
    localparam int CL_MJMP  = 7;
    localparam int CL_NDEC  = 8;               // decodable classes
    localparam int CL_ILL   = CL_NDEC;         // illegal / unknown
    localparam int CL_W     = CL_NDEC + 1;

    typedef enum logic [1:0] {
        DST_RT   = 2'b00,
        DST_RD   = 2'b01,
        DST_LINK = 2'b10
    } wb_dst_e;

    typedef enum logic [1:0] {
        SRC_ALU   = 2'b00,
        SRC_MEM   = 2'b01,
        SRC_PCINC = 2'b10
    } wb_src_e;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'b00,
        ALU_SUB   = 2'b01,
        ALU_FUNCT = 2'b10
    } alu_mode_e;

    typedef enum logic [1:0] {
        PC_SEQ  = 2'b00,
        PC_JTGT = 2'b01,
        PC_MEM  = 2'b10
    } pc_src_e;

    typedef struct packed {
        wb_dst_e   wb_dst;
        logic      alu_b_imm;
        wb_src_e   wb_src;
        logic      rf_we;
        logic      dm_re;
        logic      dm_we;
        logic      br_en;
        alu_mode_e alu_mode;
        pc_src_e   pc_src;
    } ctl_t;

    localparam ctl_t CTL_ZERO = '{
        wb_dst:    DST_RT,
        alu_b_imm: 1'b0,
        wb_src:    SRC_ALU,
        rf_we:     1'b0,
        dm_re:     1'b0,
        dm_we:     1'b0,
        br_en:     1'b0,
        alu_mode:  ALU_ADD,
        pc_src:    PC_SEQ
    };

endpackage

// File: rtl/sc_ctl_classify.sv
// Module: sc_ctl_classify
// Maps opcode and function field onto a one-hot instruction class vector.
// Assumes that the class opcodes given as parameters are distinct. The
// indexed load shares the register-format opcode and wins on its function code.
module sc_ctl_classify
    import sc_ctl_pkg::*;
#(
    parameter logic [OP_W-1:0] P_OP_RTYPE = 6'd0,
    parameter logic [OP_W-1:0] P_OP_LOAD  = 6'd35,
    parameter logic [OP_W-1:0] P_OP_STORE = 6'd43,
    parameter logic [OP_W-1:0] P_OP_BEQ   = 6'd4,
    parameter logic [OP_W-1:0] P_OP_JMP   = 6'd2,
    parameter logic [OP_W-1:0] P_OP_CALL  = 6'd3,
    parameter logic [OP_W-1:0] P_OP_MJMP  = 6'h3C,
    parameter logic [FN_W-1:0] P_FN_IDXLD = 6'h3A
) (
    input  logic [OP_W-1:0] opcode_i,
    input  logic [FN_W-1:0] funct_i,
    output logic [CL_W-1:0] class_o
);

    localparam int FN_ANY  = 0;   // function field ignored
    localparam int FN_EQ   = 1;   // function field must match
    localparam int FN_NEQ  = 2;   // function field must not match

    logic [CL_NDEC-1:0] hit;
    logic               fn_is_idx;

    // Purpose: flag the indexed-load function code once for all classes.
    always_comb begin
        fn_is_idx = (funct_i == P_FN_IDXLD);
    end

    for (genvar g = 0; g < CL_NDEC; g++) begin : g_cls
        localparam logic [OP_W-1:0] OPC =
            (g == CL_RTYPE) ? P_OP_RTYPE :
            (g == CL_IDXLD) ? P_OP_RTYPE :
            (g == CL_LOAD)  ? P_OP_LOAD  :
            (g == CL_STORE) ? P_OP_STORE :
            (g == CL_BEQ)   ? P_OP_BEQ   :
            (g == CL_JMP)   ? P_OP_JMP   :
            (g == CL_CALL)  ? P_OP_CALL  : P_OP_MJMP;
        localparam int FMODE =
            (g == CL_RTYPE) ? FN_NEQ :
            (g == CL_IDXLD) ? FN_EQ  : FN_ANY;

        // Purpose: match one class on opcode plus its function-field rule.
        always_comb begin
            if (FMODE == FN_EQ)
                hit[g] = (opcode_i == OPC) && fn_is_idx;
            else if (FMODE == FN_NEQ)
                hit[g] = (opcode_i == OPC) && !fn_is_idx;
            else
                hit[g] = (opcode_i == OPC);
        end
    end

    // Purpose: append the illegal-class bit when nothing matched.
    always_comb begin
        class_o = {~|hit, hit};
    end

endmodule

// File: rtl/sc_ctl_rows.sv
// Module: sc_ctl_rows
// Turns a one-hot class vector into the control bundle, one row per class.
// Assumes the class vector is one-hot; fields a row leaves open stay zero.
module sc_ctl_rows
    import sc_ctl_pkg::*;
(
    input  logic [CL_W-1:0] class_i,
    output ctl_t            ctl_o
);

    // Purpose: select the control row for the active class.
    always_comb begin
        ctl_o = CTL_ZERO;
        unique case (1'b1)
            class_i[CL_RTYPE]: begin
                ctl_o.wb_dst   = DST_RD;
                ctl_o.rf_we    = 1'b1;
                ctl_o.alu_mode = ALU_FUNCT;
            end
            class_i[CL_IDXLD]: begin
                ctl_o.wb_dst   = DST_RD;
                ctl_o.wb_src   = SRC_MEM;
                ctl_o.rf_we    = 1'b1;
                ctl_o.dm_re    = 1'b1;
            end
            class_i[CL_LOAD]: begin
                ctl_o.alu_b_imm = 1'b1;
                ctl_o.wb_src    = SRC_MEM;
                ctl_o.rf_we     = 1'b1;
                ctl_o.dm_re     = 1'b1;
            end
            class_i[CL_STORE]: begin
                ctl_o.alu_b_imm = 1'b1;
                ctl_o.dm_we     = 1'b1;
            end
            class_i[CL_BEQ]: begin
                ctl_o.br_en    = 1'b1;
                ctl_o.alu_mode = ALU_SUB;
            end
            class_i[CL_JMP]: begin
                ctl_o.pc_src = PC_JTGT;
            end
            class_i[CL_CALL]: begin
                ctl_o.wb_dst = DST_LINK;
                ctl_o.wb_src = SRC_PCINC;
                ctl_o.rf_we  = 1'b1;
                ctl_o.pc_src = PC_JTGT;
            end
            class_i[CL_MJMP]: begin
                ctl_o.alu_b_imm = 1'b1;
                ctl_o.dm_re     = 1'b1;
                ctl_o.pc_src    = PC_MEM;
            end
            default: ctl_o = CTL_ZERO;
        endcase
    end

    // Purpose: guard the one-hot contract from the classifier (R10).
    always_comb begin
        if (!$isunknown(class_i)) begin
            assert_class_onehot_R10: assert ($onehot(class_i));
        end
    end

endmodule

// File: rtl/sc_main_ctl.sv
// Module: sc_main_ctl
// Top of the single-cycle main control decoder: classify, look up row, drive pins.
// Assumes instruction fields are stable for the whole cycle; purely combinational.
module sc_main_ctl
    import sc_ctl_pkg::*;
#(
    parameter logic [5:0] P_OP_RTYPE = 6'd0,
    parameter logic [5:0] P_OP_LOAD  = 6'd35,
    parameter logic [5:0] P_OP_STORE = 6'd43,
    parameter logic [5:0] P_OP_BEQ   = 6'd4,
    parameter logic [5:0] P_OP_JMP   = 6'd2,
    parameter logic [5:0] P_OP_CALL  = 6'd3,
    parameter logic [5:0] P_OP_MJMP  = 6'h3C,
    parameter logic [5:0] P_FN_IDXLD = 6'h3A
) (
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output logic [1:0] wb_dst_sel_o,
    output logic       alu_b_imm_o,
    output logic [1:0] wb_src_sel_o,
    output logic       rf_we_o,
    output logic       dm_re_o,
    output logic       dm_we_o,
    output logic       br_en_o,
    output logic [1:0] alu_mode_o,
    output logic [1:0] pc_src_sel_o
);

    logic [CL_W-1:0] cls;
    ctl_t            ctl;

    sc_ctl_classify #(
        .P_OP_RTYPE (P_OP_RTYPE),
        .P_OP_LOAD  (P_OP_LOAD),
        .P_OP_STORE (P_OP_STORE),
        .P_OP_BEQ   (P_OP_BEQ),
        .P_OP_JMP   (P_OP_JMP),
        .P_OP_CALL  (P_OP_CALL),
        .P_OP_MJMP  (P_OP_MJMP),
        .P_FN_IDXLD (P_FN_IDXLD)
    ) classify_i (
        .opcode_i (opcode_i),
        .funct_i  (funct_i),
        .class_o  (cls)
    );

    sc_ctl_rows rows_i (
        .class_i (cls),
        .ctl_o   (ctl)
    );

    // Purpose: flatten the control bundle onto plain output pins.
    always_comb begin
        wb_dst_sel_o = ctl.wb_dst;
        alu_b_imm_o  = ctl.alu_b_imm;
        wb_src_sel_o = ctl.wb_src;
        rf_we_o      = ctl.rf_we;
        dm_re_o      = ctl.dm_re;
        dm_we_o      = ctl.dm_we;
        br_en_o      = ctl.br_en;
        alu_mode_o   = ctl.alu_mode;
        pc_src_sel_o = ctl.pc_src;
    end

    // Purpose: check cross-field consistency of the driven controls.
    always_comb begin
        if (!$isunknown({opcode_i, funct_i})) begin
            assert_no_rw_clash_R11: assert (!(dm_re_o && dm_we_o));
            assert_no_sel11_R11: assert (wb_dst_sel_o != 2'b11 && wb_src_sel_o != 2'b11
                                         && pc_src_sel_o != 2'b11 && alu_mode_o != 2'b11);
            assert_link_pairs_R6: assert (wb_dst_sel_o != 2'b10
                                          || (wb_src_sel_o == 2'b10 && rf_we_o && pc_src_sel_o == 2'b01));
            assert_memjump_reads_R8: assert (pc_src_sel_o != 2'b10
                                             || (dm_re_o && !rf_we_o && alu_b_imm_o));
            assert_illegal_quiet_R9: assert (opcode_i inside {P_OP_RTYPE, P_OP_LOAD, P_OP_STORE,
                                             P_OP_BEQ, P_OP_JMP, P_OP_CALL, P_OP_MJMP}
                                             || {rf_we_o, dm_re_o, dm_we_o, br_en_o, pc_src_sel_o} == 6'd0);
            assert_idx_load_R7: assert (!(opcode_i == P_OP_RTYPE && funct_i == P_FN_IDXLD)
                                        || (dm_re_o && alu_mode_o == 2'b00 && wb_dst_sel_o == 2'b01));
        end
    end

endmodule

// File: tb/sc_main_ctl_tb_top.sv
// Bench: directed scenarios, one task each, for the main control decoder.
module sc_main_ctl_tb_top;

    logic       clk = 1'b0;
    logic [5:0] opcode;
    logic [5:0] funct;
    logic [1:0] wb_dst, wb_src, alu_mode, pc_src;
    logic       alu_b_imm, rf_we, dm_re, dm_we, br_en;
    int         n_total = 0;
    int         n_bad   = 0;
    bit         done    = 1'b0;

    // Vector layout: dst[12:11] bimm[10] src[9:8] we[7] re[6] wr[5] br[4] alu[3:2] pc[1:0]
    localparam logic [12:0] V_RTYPE = 13'b01_0_00_1_0_0_0_10_00;
    localparam logic [12:0] V_LOAD  = 13'b00_1_01_1_1_0_0_00_00;
    localparam logic [12:0] V_STORE = 13'b00_1_00_0_0_1_0_00_00;
    localparam logic [12:0] V_BEQ   = 13'b00_0_00_0_0_0_1_01_00;
    localparam logic [12:0] V_JMP   = 13'b00_0_00_0_0_0_0_00_01;
    localparam logic [12:0] V_CALL  = 13'b10_0_10_1_0_0_0_00_01;
    localparam logic [12:0] V_IDXLD = 13'b01_0_01_1_1_0_0_00_00;
    localparam logic [12:0] V_MJMP  = 13'b00_1_00_0_1_0_0_00_10;
    localparam logic [12:0] V_ZERO  = 13'd0;

    always #2 clk = ~clk;

    sc_main_ctl dut_i (
        .opcode_i     (opcode),
        .funct_i      (funct),
        .wb_dst_sel_o (wb_dst),
        .alu_b_imm_o  (alu_b_imm),
        .wb_src_sel_o (wb_src),
        .rf_we_o      (rf_we),
        .dm_re_o      (dm_re),
        .dm_we_o      (dm_we),
        .br_en_o      (br_en),
        .alu_mode_o   (alu_mode),
        .pc_src_sel_o (pc_src)
    );

    task automatic apply_check(input logic [5:0] op, input logic [5:0] fn,
                               input logic [12:0] exp, input string req);
        logic [12:0] got;
        @(posedge clk);
        opcode = op;
        funct  = fn;
        @(negedge clk);
        got = {wb_dst, alu_b_imm, wb_src, rf_we, dm_re, dm_we, br_en, alu_mode, pc_src};
        n_total++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d fn=%0h actual=%b expected=%b", req, op, fn, got, exp);
        end
    endtask

    task automatic t_rtype();  // R1
        apply_check(6'd0, 6'h20, V_RTYPE, "R1");
        apply_check(6'd0, 6'h22, V_RTYPE, "R1");
        apply_check(6'd0, 6'h3B, V_RTYPE, "R1");
        apply_check(6'd0, 6'h39, V_RTYPE, "R1");
        apply_check(6'd0, 6'h00, V_RTYPE, "R1");
    endtask

    task automatic t_load();   // R2: function field has no effect
        apply_check(6'd35, 6'h00, V_LOAD, "R2");
        apply_check(6'd35, 6'h3A, V_LOAD, "R2");
        apply_check(6'd35, 6'h3F, V_LOAD, "R2");
    endtask

    task automatic t_store();  // R3
        apply_check(6'd43, 6'h00, V_STORE, "R3");
        apply_check(6'd43, 6'h3A, V_STORE, "R3");
    endtask

    task automatic t_beq();    // R4
        apply_check(6'd4, 6'h15, V_BEQ, "R4");
    endtask

    task automatic t_jump();   // R5
        apply_check(6'd2, 6'h3A, V_JMP, "R5");
    endtask

    task automatic t_call();   // R6
        apply_check(6'd3, 6'h00, V_CALL, "R6");
        apply_check(6'd3, 6'h3A, V_CALL, "R6");
    endtask

    task automatic t_idxload(); // R7: priority over the register-format row
        apply_check(6'd0, 6'h3A, V_IDXLD, "R7");
        apply_check(6'd0, 6'h20, V_RTYPE, "R7");
        apply_check(6'd0, 6'h3A, V_IDXLD, "R7");
    endtask

    task automatic t_memjump(); // R8
        apply_check(6'h3C, 6'h00, V_MJMP, "R8");
        apply_check(6'h3C, 6'h3A, V_MJMP, "R8");
    endtask

    task automatic t_illegal(); // R9, R10, R11: every undecoded opcode is all-zero
        for (int op = 0; op < 64; op++) begin
            if (!(op inside {0, 2, 3, 4, 35, 43, 60})) begin
                apply_check(6'(op), 6'h3A, V_ZERO, "R9");
            end
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        opcode = 6'd0;
        funct  = 6'h20;
        t_rtype();
        t_load();
        t_store();
        t_beq();
        t_jump();
        t_call();
        t_idxload();
        t_memjump();
        t_illegal();
        apply_check(6'd0, 6'h3A, V_IDXLD, "R10");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule